// File: doc/BRIEF.md
# Accumulator Pipelined Datapath

This block is the execution core of a small 8-bit machine whose only architectural register is an accumulator. It accepts one 16-bit instruction word per clock, decodes it, reads an operand from an internal 256-byte data memory or takes a literal, combines it with the accumulator in an ALU, and writes the result to the accumulator or back to memory. The work is spread over three stages: decode, read/execute, and writeback.

An external program-counter controller drives the instruction stream. Each cycle it sees the condition flags of the instruction in the execute stage, so it can decide on skips. When it needs to squash a wrongly issued instruction, it raises a kill line while that instruction sits in decode. The instruction then flows on, but it writes nothing. The ALU output of the writeback stage feeds back into the operand read path, and the accumulator is forwarded the same way. Dependent instructions can therefore issue back to back with no stall.

Top module: `acc_datapath`

## Requirements
- R1: While reset is low, and after it is released until a new instruction arrives, `acc_out` is 0 and `flag_valid` is low.
- R2: The opcode is bits [15:8] and the address or literal is bits [7:0]. Bit 15 set sends the result to memory at the address; bit 15 clear sends it to the accumulator. Bit 14 set selects the literal as operand; bit 14 clear selects memory. Bits [10:8] select the function: 0 load operand, 1 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 pass accumulator (with bit 15 this is a store). A result never goes to both destinations.
- R3: An instruction captured on clock edge k writes its result on edge k+3. One instruction can be accepted per cycle.
- R4: Add and subtract wrap modulo 256. AND, OR and XOR act bitwise on the accumulator and the operand.
- R5: An instruction that reads a memory address the previous instruction writes sees the new value, with no stall.
- R6: An instruction that uses the accumulator right after one that writes it sees the new value, with no stall.
- R7: Raising `kill` while an instruction is in decode (the cycle after it is issued) stops it from changing the accumulator or memory. Its result is never forwarded, and its flags are not reported.
- R8: Encodings with bits [13:11] nonzero, function 7, or both bit 15 and bit 14 set write nothing.
- R9: `flag_valid` is high for exactly the cycle a live, non-killed instruction is in execute, one cycle after it is issued. `flag_zero` then means its result is 0, `flag_neg` is result bit 7, and `flag_carry` is the add carry-out or the subtract borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_instr | input | 16 | Instruction word |
| kill | input | 1 | Squash the instruction now in decode |
| acc_out | output | 8 | Accumulator value |
| flag_valid | output | 1 | Flags below belong to a live instruction in execute |
| flag_zero | output | 1 | Execute-stage result is zero |
| flag_neg | output | 1 | Execute-stage result bit 7 |
| flag_carry | output | 1 | Add carry-out or subtract borrow |

## Verification
The hardest case to reach from the ports is a killed memory write followed directly by a read of the same address. A broken bypass would wrongly forward the squashed data in that case. The vector stream first stores a known value, then loads a different accumulator value, issues a killed store to the same address, and reads that address in the very next slot. All of this runs back to back, so every read meets its producer in the writeback stage. Other vectors exercise accumulator forwarding, memory-destination ALU results feeding a load, and each class of undefined encoding.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DW  = 8;
    localparam int IW  = 16;
    localparam int OPW = IW - DW;
    localparam int FNW = 3;

    typedef enum logic [FNW-1:0] {
        FN_LOAD = 3'd0,
        FN_ADD  = 3'd1,
        FN_SUB  = 3'd2,
        FN_AND  = 3'd3,
        FN_OR   = 3'd4,
        FN_XOR  = 3'd5,
        FN_PASS = 3'd6,
        FN_BAD  = 3'd7
    } fn_e;

    typedef struct packed {
        logic          valid;
        logic          killed;
        fn_e           fn;
        logic          imm;
        logic          to_acc;
        logic          to_mem;
        logic [DW-1:0] field;
    } exe_t;

    typedef struct packed {
        logic          valid;
        logic          killed;
        logic          to_acc;
        logic          to_mem;
        logic [DW-1:0] field;
        logic [DW-1:0] data;
    } wbk_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [IW-1:0] instr,
    output fn_e           fn,
    output logic          imm,
    output logic          to_acc,
    output logic          to_mem,
    output logic [DW-1:0] field
);
    logic [OPW-1:0] op;
    logic           legal;

    always_comb begin
        op     = instr[IW-1:DW];
        field  = instr[DW-1:0];
        fn     = fn_e'(op[FNW-1:0]);
        imm    = op[OPW-2];
        legal  = (op[OPW-3:FNW] == '0) && (fn != FN_BAD) && !(op[OPW-1] && op[OPW-2]);
        to_mem = legal && op[OPW-1];
        to_acc = legal && !op[OPW-1];
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  fn_e           fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          carry
);
    logic [DW:0] wide;

    always_comb begin
        wide = '0;
        unique case (fn)
            FN_LOAD: wide = {1'b0, b};
            FN_ADD:  wide = {1'b0, a} + {1'b0, b};
            FN_SUB:  wide = {1'b0, a} - {1'b0, b};
            FN_AND:  wide = {1'b0, a & b};
            FN_OR:   wide = {1'b0, a | b};
            FN_XOR:  wide = {1'b0, a ^ b};
            FN_PASS: wide = {1'b0, a};
            default: wide = '0;
        endcase
        res   = wide[DW-1:0];
        carry = wide[DW] && ((fn == FN_ADD) || (fn == FN_SUB));
    end
endmodule

// File: rtl/acc_dmem.sv
module acc_dmem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells_q[wr_addr] <= wr_data;
    end

    assign rd_data = cells_q[rd_addr];
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [IW-1:0] issue_instr,
    input  logic          kill,
    output logic [DW-1:0] acc_out,
    output logic          flag_valid,
    output logic          flag_zero,
    output logic          flag_neg,
    output logic          flag_carry
);
    typedef struct packed {
        logic          dec_valid;
        logic [IW-1:0] dec_instr;
        exe_t          exe;
        wbk_t          wbk;
        logic [DW-1:0] acc;
    } state_t;

    state_t st_d, st_q;

    fn_e           dec_fn;
    logic          dec_imm, dec_to_acc, dec_to_mem;
    logic [DW-1:0] dec_field;
    logic [DW-1:0] mem_rd;
    logic [DW-1:0] alu_res;
    logic          alu_carry;
    logic [DW-1:0] acc_fwd, mem_fwd, operand;
    logic          wb_live, acc_we, mem_we;

    acc_decode u_decode (
        .instr  (st_q.dec_instr),
        .fn     (dec_fn),
        .imm    (dec_imm),
        .to_acc (dec_to_acc),
        .to_mem (dec_to_mem),
        .field  (dec_field)
    );

    acc_dmem #(.AW(DW), .DW(DW)) u_dmem (
        .clk     (clk),
        .rd_addr (st_q.exe.field),
        .rd_data (mem_rd),
        .wr_en   (mem_we),
        .wr_addr (st_q.wbk.field),
        .wr_data (st_q.wbk.data)
    );

    acc_alu u_alu (
        .fn    (st_q.exe.fn),
        .a     (acc_fwd),
        .b     (operand),
        .res   (alu_res),
        .carry (alu_carry)
    );

    always_comb begin
        wb_live = st_q.wbk.valid && !st_q.wbk.killed;
        acc_we  = wb_live && st_q.wbk.to_acc;
        mem_we  = wb_live && st_q.wbk.to_mem;
        acc_fwd = acc_we ? st_q.wbk.data : st_q.acc;
        mem_fwd = (mem_we && (st_q.wbk.field == st_q.exe.field)) ? st_q.wbk.data : mem_rd;
        operand = st_q.exe.imm ? st_q.exe.field : mem_fwd;

        st_d = st_q;
        st_d.dec_valid  = issue_valid;
        st_d.dec_instr  = issue_instr;

        st_d.exe.valid  = st_q.dec_valid;
        st_d.exe.killed = st_q.dec_valid && kill;
        st_d.exe.fn     = dec_fn;
        st_d.exe.imm    = dec_imm;
        st_d.exe.to_acc = dec_to_acc;
        st_d.exe.to_mem = dec_to_mem;
        st_d.exe.field  = dec_field;

        st_d.wbk.valid  = st_q.exe.valid;
        st_d.wbk.killed = st_q.exe.killed;
        st_d.wbk.to_acc = st_q.exe.to_acc;
        st_d.wbk.to_mem = st_q.exe.to_mem;
        st_d.wbk.field  = st_q.exe.field;
        st_d.wbk.data   = alu_res;

        st_d.acc = acc_fwd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out    = st_q.acc;
    assign flag_valid = st_q.exe.valid && !st_q.exe.killed;
    assign flag_zero  = (alu_res == '0);
    assign flag_neg   = alu_res[DW-1];
    assign flag_carry = alu_carry;

    // R7
    killed_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && st_q.dec_valid) |=> !flag_valid);

    // R9
    flag_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dec_valid && !kill) |=> flag_valid);

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_we |=> $stable(acc_out));

    // R2
    single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_we && mem_we));
endmodule

// File: tb/acc_datapath_bench.sv
`timescale 1ns/1ps
module acc_datapath_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [15:0] issue_instr;
    logic        kill;
    logic [7:0]  acc_out;
    logic        flag_valid, flag_zero, flag_neg, flag_carry;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acc_datapath u_acc_datapath (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .kill(kill), .acc_out(acc_out), .flag_valid(flag_valid), .flag_zero(flag_zero),
        .flag_neg(flag_neg), .flag_carry(flag_carry)
    );

    // {instr, kill, expected accumulator once it retires}
    localparam int NV = 23;
    localparam logic [24:0] VEC [NV] = '{
        {16'h405A, 1'b0, 8'h5A},  // R2 load literal
        {16'h8610, 1'b0, 8'h5A},  // R2 store to 0x10
        {16'h0110, 1'b0, 8'hB4},  // R5 R6 add mem right after store
        {16'h4204, 1'b0, 8'hB0},  // R4 subtract literal
        {16'h8620, 1'b0, 8'hB0},  // store to 0x20
        {16'h0520, 1'b0, 8'h00},  // R5 xor mem
        {16'h440F, 1'b0, 8'h0F},  // R4 or literal
        {16'h433C, 1'b0, 8'h0C},  // R6 and literal
        {16'h0110, 1'b1, 8'h0C},  // R7 killed add
        {16'h0010, 1'b0, 8'h5A},  // load mem
        {16'h41C0, 1'b0, 8'h1A},  // R4 add wraps
        {16'h8110, 1'b0, 8'h1A},  // add into memory 0x10
        {16'h0010, 1'b0, 8'h74},  // R5 read ALU result just written
        {16'h4011, 1'b0, 8'h11},
        {16'h8630, 1'b0, 8'h11},  // store 0x11 to 0x30
        {16'h4022, 1'b0, 8'h22},
        {16'h8630, 1'b1, 8'h22},  // R7 killed store
        {16'h0030, 1'b0, 8'h11},  // R7 killed store not forwarded
        {16'h0730, 1'b0, 8'h11},  // R8 function 7
        {16'h0230, 1'b0, 8'h00},  // R4 subtract mem
        {16'h2810, 1'b0, 8'h00},  // R8 reserved bits set
        {16'hC010, 1'b0, 8'h00},  // R8 memory dest with literal
        {16'h0010, 1'b0, 8'h74}   // R8 memory untouched
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [15:0] ins, input logic k);
        issue_valid = v;
        issue_instr = ins;
        kill        = k;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        issue_valid = 1'b0; issue_instr = '0; kill = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 acc", acc_out, 8'h00);
        check("R1 flag_valid", {7'd0, flag_valid}, 8'h00);

        // R3 back-to-back stream: acc reflects instruction n-3 after edge n
        for (int n = 0; n < NV + 3; n++) begin
            logic k;
            k = (n >= 1 && n - 1 < NV) ? VEC[n-1][8] : 1'b0;
            if (n < NV) cycle(1'b1, VEC[n][24:9], k);
            else        cycle(1'b0, 16'h0000, k);
            if (n >= 3) check("R3 stream acc", acc_out, VEC[n-3][7:0]);
        end

        // R9 flags
        do_reset();
        cycle(1'b1, 16'h4001, 1'b0);
        cycle(1'b1, 16'h41FF, 1'b0);
        check("R9 valid load", {7'd0, flag_valid}, 8'h01);
        check("R9 zero load", {7'd0, flag_zero}, 8'h00);
        cycle(1'b1, 16'h4201, 1'b0);
        check("R9 add flags v/z/n/c", {4'd0, flag_valid, flag_zero, flag_neg, flag_carry}, 8'h0D);
        cycle(1'b1, 16'h4000, 1'b0);
        check("R9 sub flags v/z/n/c", {4'd0, flag_valid, flag_zero, flag_neg, flag_carry}, 8'h0B);
        cycle(1'b0, 16'h0000, 1'b1);
        check("R7 killed no flags", {7'd0, flag_valid}, 8'h00);
        cycle(1'b0, 16'h0000, 1'b0);
        check("R9 bubble no flags", {7'd0, flag_valid}, 8'h00);
        cycle(1'b0, 16'h0000, 1'b0);
        check("R7 killed load leaves acc", acc_out, 8'hFF);

        // R1 reset mid-run
        do_reset();
        check("R1 acc after reset", acc_out, 8'h00);
        check("R1 flag after reset", {7'd0, flag_valid}, 8'h00);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule